// File: doc/BRIEF.md
# Matrix Keyboard Scanner

This block scans a key matrix of up to sixteen rows and eight columns. It runs from a slow scan clock and drives a single row at a time while it samples the column inputs. For each key it applies a programmable debounce window. At the end of every full scan it publishes a snapshot of up to eight pressed keys, a count of valid entries, and a threshold flag that can raise an interrupt.

Software reaches the block through a small word-indexed register port. Index 0 is the control word, index 1 is the status word, and indices 2 and 3 are the two words that carry the packed entries. Reads are combinational. A write takes effect at the clock edge that samples it.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset, `rowDrive` and `irq` are 0, and all four register words read 0.
- R2: Once the enable bit is written as 1, the block waits a start delay of 5 cycles. Row 0 is first driven 6 clock edges after the write edge. Rows are then driven one-hot in ascending order, each for 16 + debounce cycles. After row 15 the start delay repeats and a new scan begins.
- R3: A key enters the snapshot only if its column was high on more than `debounce` consecutive cycles ending at the last cycle of its row's window. A key whose contact keeps toggling is left out.
- R4: Each entry is 8 bits: bit 7 is valid, bits 6:3 hold the row and bits 2:0 hold the column. Entries 0 to 3 read from index 2 and entries 4 to 7 from index 3, with the lowest entry in the least significant byte.
- R5: Entries are ordered by ascending row, then by ascending column. Unused slots read 0. If more than 8 keys are down, the first 8 in scan order are kept and the count is 8.
- R6: The snapshot and the count in status bits 7:4 change only at the clock edge that ends the last row of a scan. That edge is 256 + 16 × debounce edges after row 0 is first driven. A released key disappears at the next complete scan.
- R7: Status bit 2 is set at the end of a scan if the new count is at least the nonzero threshold. Writing 1 to status bit 2 clears it; writing 0x7 clears it as well.
- R8: `irq` is high exactly while status bit 2 is set and control bit 3 is 1.
- R9: Writing the enable bit as 0 stops row driving from the next cycle on. The snapshot and count are kept while the block is disabled.
- R10: The control word holds enable in bit 0, interrupt enable in bit 3, the debounce count in bits 13:4 (at most 0x3FF) and the threshold in bits 17:14. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 2 | Register word index (0 control, 1 status, 2/3 entries) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for `regIdx` |
| colIn | input | 8 | Column sense inputs, high when a key on the driven row is closed |
| rowDrive | output | 16 | One-hot row drive, high on the active row |
| irq | output | 1 | Count-threshold interrupt |

## Verification
Every result has a fixed latency from the write edge that enables scanning. Row 0 appears 6 edges later, and each following row appears 16 + debounce edges after the row before it. The snapshot, count and threshold flag change at the edge 256 + 16 × debounce edges after row 0 first appears. The bench counts edges from the write edge and samples on falling edges. It checks the row and commit times on the exact edges, one cycle before and on the edge itself. For content checks it waits two full scan periods, so that one complete scan has seen the new key pattern, and register writes and disables are checked one falling edge after the edge that samples them.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

  localparam int DBC_W       = 10;
  localparam int THR_W       = 4;
  localparam int MAX_ENTRIES = 8;
  localparam int ENT_CNT_W   = $clog2(MAX_ENTRIES + 1);
  localparam int ENT_IDX_W   = $clog2(MAX_ENTRIES);

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_IRQEN_BIT = 3;
  localparam int CTL_DBC_LSB   = 4;
  localparam int CTL_THR_LSB   = 14;
  localparam int STA_THR_BIT   = 2;
  localparam int STA_CNT_LSB   = 4;

  typedef struct packed {
    logic       valid;
    logic [3:0] row;
    logic [2:0] col;
  } keyEntry_t;

  typedef struct packed {
    logic rowStart;
    logic rowEnd;
    logic scanEnd;
  } scanStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DELAY = 2'd1,
    S_ROW   = 2'd2
  } scanState_t;

endpackage

// File: rtl/kbd_scan_ctrl.sv
module kbd_scan_ctrl
  import kbd_scan_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int ROW_CYCLES = 16,
  parameter int START_DLY  = 5,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS),
  localparam int CNT_W     = $clog2(ROW_CYCLES + (1 << DBC_W) + START_DLY)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [DBC_W-1:0]     dbc,
  output scanStrobe_t          strobe,
  output logic [ROW_IDX_W-1:0] rowIdx,
  output logic [NUM_ROWS-1:0]  rowDrive
);

  scanState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] winLast;
  logic             rowActive;

  assign winLast   = CNT_W'(ROW_CYCLES) + CNT_W'(dbc) - CNT_W'(1);
  assign rowActive = enable && (state == S_ROW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rowIdx <= '0;
    end else if (!enable) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rowIdx <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          state <= S_DELAY;
          cnt   <= '0;
        end
        S_DELAY: begin
          if (cnt == CNT_W'(START_DLY - 1)) begin
            state  <= S_ROW;
            cnt    <= '0;
            rowIdx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ROW: begin
          if (cnt == winLast) begin
            cnt <= '0;
            if (rowIdx == ROW_IDX_W'(NUM_ROWS - 1)) begin
              state  <= S_DELAY;
              rowIdx <= '0;
            end else begin
              rowIdx <= rowIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.rowStart = rowActive && (cnt == '0);
    strobe.rowEnd   = rowActive && (cnt == winLast);
    strobe.scanEnd  = strobe.rowEnd && (rowIdx == ROW_IDX_W'(NUM_ROWS - 1));
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_drive
    assign rowDrive[r] = rowActive && (rowIdx == ROW_IDX_W'(r));
  end

endmodule

// File: rtl/kbd_scan_datapath.sv
module kbd_scan_datapath
  import kbd_scan_pkg::*;
#(
  parameter int NUM_ROWS  = 16,
  parameter int NUM_COLS  = 8,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS),
  localparam int RUN_W     = DBC_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scanStrobe_t                   strobe,
  input  logic [ROW_IDX_W-1:0]          rowIdx,
  input  logic [NUM_COLS-1:0]           colIn,
  input  logic [DBC_W-1:0]              dbc,
  output logic [MAX_ENTRIES*8-1:0]      entFlat,
  output logic [MAX_ENTRIES-1:0]        validBits,
  output logic [ENT_CNT_W-1:0]          entCount,
  output logic [ENT_CNT_W-1:0]          nextCount
);

  logic [RUN_W-1:0] runCnt [NUM_COLS];
  logic [RUN_W-1:0] newRun [NUM_COLS];
  logic [NUM_COLS-1:0] pressed;

  keyEntry_t [MAX_ENTRIES-1:0] pend;
  keyEntry_t [MAX_ENTRIES-1:0] snap;
  keyEntry_t [MAX_ENTRIES-1:0] addList;
  logic [ENT_CNT_W-1:0]        pendCnt;
  logic [ENT_CNT_W-1:0]        addCnt;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_comb begin
      if (!colIn[c])                 newRun[c] = '0;
      else if (strobe.rowStart)      newRun[c] = RUN_W'(1);
      else if (runCnt[c] == '1)      newRun[c] = runCnt[c];
      else                           newRun[c] = runCnt[c] + 1'b1;
    end
    assign pressed[c] = newRun[c] > RUN_W'(dbc);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) runCnt[c] <= '0;
      else       runCnt[c] <= newRun[c];
    end
  end

  always_comb begin
    addList = pend;
    addCnt  = pendCnt;
    if (strobe.rowEnd) begin
      for (int c = 0; c < NUM_COLS; c++) begin
        if (pressed[c] && (addCnt < ENT_CNT_W'(MAX_ENTRIES))) begin
          addList[addCnt[ENT_IDX_W-1:0]].valid = 1'b1;
          addList[addCnt[ENT_IDX_W-1:0]].row   = 4'(rowIdx);
          addList[addCnt[ENT_IDX_W-1:0]].col   = 3'(c);
          addCnt = addCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= '0;
      pendCnt  <= '0;
      snap     <= '0;
      entCount <= '0;
    end else begin
      if (strobe.rowStart && (rowIdx == '0)) begin
        pend    <= '0;
        pendCnt <= '0;
      end else if (strobe.rowEnd) begin
        pend    <= addList;
        pendCnt <= addCnt;
      end
      if (strobe.scanEnd) begin
        snap     <= addList;
        entCount <= addCnt;
      end
    end
  end

  assign entFlat   = snap;
  assign nextCount = addCnt;

  for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_valid
    assign validBits[i] = snap[i].valid;
  end

endmodule

// File: rtl/kbd_scan_regs.sv
module kbd_scan_regs
  import kbd_scan_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [1:0]               regIdx,
  input  logic [31:0]              regWdata,
  output logic [31:0]              regRdata,
  input  logic [MAX_ENTRIES*8-1:0] entFlat,
  input  logic [ENT_CNT_W-1:0]     entCount,
  input  logic                     commit,
  input  logic [ENT_CNT_W-1:0]     nextCount,
  output logic                     enable,
  output logic [DBC_W-1:0]         dbc,
  output logic                     irq
);

  logic             irqEn;
  logic [THR_W-1:0] thr;
  logic             thrStat;
  logic             ctlWr;
  logic             staWr;
  logic             thrHit;

  assign ctlWr  = regWe && (regIdx == 2'd0);
  assign staWr  = regWe && (regIdx == 2'd1);
  assign thrHit = commit && (thr != '0) && (ENT_CNT_W'(nextCount) >= ENT_CNT_W'(thr));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      irqEn   <= 1'b0;
      dbc     <= '0;
      thr     <= '0;
      thrStat <= 1'b0;
    end else begin
      if (ctlWr) begin
        enable <= regWdata[CTL_EN_BIT];
        irqEn  <= regWdata[CTL_IRQEN_BIT];
        dbc    <= regWdata[CTL_DBC_LSB +: DBC_W];
        thr    <= regWdata[CTL_THR_LSB +: THR_W];
      end
      if (thrHit)                            thrStat <= 1'b1;
      else if (staWr && regWdata[STA_THR_BIT]) thrStat <= 1'b0;
    end
  end

  assign irq = thrStat && irqEn;

  always_comb begin
    regRdata = '0;
    unique case (regIdx)
      2'd0: begin
        regRdata[CTL_EN_BIT]                = enable;
        regRdata[CTL_IRQEN_BIT]             = irqEn;
        regRdata[CTL_DBC_LSB +: DBC_W]      = dbc;
        regRdata[CTL_THR_LSB +: THR_W]      = thr;
      end
      2'd1: begin
        regRdata[STA_THR_BIT]               = thrStat;
        regRdata[STA_CNT_LSB +: ENT_CNT_W]  = entCount;
      end
      2'd2: regRdata = entFlat[31:0];
      default: regRdata = entFlat[63:32];
    endcase
  end

endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
  import kbd_scan_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int NUM_COLS   = 8,
  parameter int ROW_CYCLES = 16,
  parameter int START_DLY  = 5,
  localparam int ROW_IDX_W = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regIdx,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_COLS-1:0] colIn,
  output logic [NUM_ROWS-1:0] rowDrive,
  output logic                irq
);

  scanStrobe_t              strobe;
  logic [ROW_IDX_W-1:0]     rowIdx;
  logic                     enable;
  logic [DBC_W-1:0]         dbc;
  logic [MAX_ENTRIES*8-1:0] entFlat;
  logic [MAX_ENTRIES-1:0]   validBits;
  logic [ENT_CNT_W-1:0]     entCount;
  logic [ENT_CNT_W-1:0]     nextCount;
  logic                     scanCommit;

  assign scanCommit = strobe.scanEnd;

  kbd_scan_ctrl #(
    .NUM_ROWS  (NUM_ROWS),
    .ROW_CYCLES(ROW_CYCLES),
    .START_DLY (START_DLY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .dbc     (dbc),
    .strobe  (strobe),
    .rowIdx  (rowIdx),
    .rowDrive(rowDrive)
  );

  kbd_scan_datapath #(
    .NUM_ROWS(NUM_ROWS),
    .NUM_COLS(NUM_COLS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rowIdx   (rowIdx),
    .colIn    (colIn),
    .dbc      (dbc),
    .entFlat  (entFlat),
    .validBits(validBits),
    .entCount (entCount),
    .nextCount(nextCount)
  );

  kbd_scan_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regIdx   (regIdx),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .entFlat  (entFlat),
    .entCount (entCount),
    .commit   (scanCommit),
    .nextCount(nextCount),
    .enable   (enable),
    .dbc      (dbc),
    .irq      (irq)
  );

endmodule

// File: rtl/kbd_scan_checker.sv
module kbd_scan_checker
  import kbd_scan_pkg::*;
#(
  parameter int NUM_ROWS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWe,
  input logic [1:0]           regIdx,
  input logic [31:0]          regWdata,
  input logic [NUM_ROWS-1:0]  rowDrive,
  input logic                 irq,
  input logic                 commit,
  input logic [ENT_CNT_W-1:0] entCount,
  input logic [MAX_ENTRIES-1:0] validBits
);

  p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowDrive));

  p_stop_rows_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regIdx == 2'd0 && !regWdata[CTL_EN_BIT]) |=> (rowDrive == '0));

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(entCount));

  p_count_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    entCount <= ENT_CNT_W'(MAX_ENTRIES));

  p_valid_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validBits) == int'(entCount));

  p_clear_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regIdx == 2'd1 && regWdata[STA_THR_BIT] && !commit) |=> !irq);

endmodule

bind kbd_matrix_scan kbd_scan_checker #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regIdx   (regIdx),
  .regWdata (regWdata),
  .rowDrive (rowDrive),
  .irq      (irq),
  .commit   (scanCommit),
  .entCount (entCount),
  .validBits(validBits)
);

// File: tb/kbd_matrix_scan_tb.sv
`timescale 1ns/1ps
module kbd_matrix_scan_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regIdx = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  colIn;
  logic [15:0] rowDrive;
  logic        irq;

  logic [7:0]  keys [16];
  logic        bounceEn = 1'b0;
  logic        bouncePh = 1'b0;
  int          nChk = 0;
  int          nFail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) bouncePh <= ~bouncePh;

  kbd_matrix_scan u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .colIn(colIn),
    .rowDrive(rowDrive), .irq(irq)
  );

  always_comb begin
    colIn = '0;
    for (int r = 0; r < 16; r++) if (rowDrive[r]) colIn = colIn | keys[r];
    if (bounceEn && rowDrive[2]) colIn[1] = bouncePh;
  end

  function automatic logic [7:0] ent(int r, int c);
    return 8'(8'h80 | (r << 3) | c);
  endfunction

  function automatic logic [31:0] ctl(bit en, bit ie, int d, int t);
    return 32'(en) | (32'(ie) << 3) | (32'(d) << 4) | (32'(t) << 14);
  endfunction

  function automatic int period(int d);
    return 2 * (5 + 16 * (16 + d)) + 10;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    regIdx = idx;
    #1;
    d = regRdata;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setCtl(bit en, bit ie, int d, int t);
    wr(2'd0, ctl(1'b0, ie, d, t));
    wr(2'd0, ctl(en, ie, d, t));
  endtask

  task automatic clearKeys();
    for (int r = 0; r < 16; r++) keys[r] = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(rowDrive == '0, "R1 rowDrive", 32'(rowDrive), 0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      check(d == 0, "R1 register", d, 0);
    end
  endtask

  task automatic t_timing();
    logic [31:0] d;
    keys[3] = 8'h20;
    wr(2'd0, ctl(1'b1, 1'b0, 0, 0));
    repeat (5) @(negedge clk);
    check(rowDrive == 16'h0, "R2 start delay", 32'(rowDrive), 0);
    @(negedge clk);
    check(rowDrive == 16'h1, "R2 row0 on edge 6", 32'(rowDrive), 1);
    repeat (15) @(negedge clk);
    check(rowDrive == 16'h1, "R2 row0 held 16", 32'(rowDrive), 1);
    @(negedge clk);
    check(rowDrive == 16'h2, "R2 row1 next", 32'(rowDrive), 2);
    repeat (239) @(negedge clk);
    rd(2'd1, d);
    check(d[7:4] == 4'd0, "R6 count before commit", 32'(d[7:4]), 0);
    @(negedge clk);
    rd(2'd1, d);
    check(d[7:4] == 4'd1, "R6 count on commit edge", 32'(d[7:4]), 1);
    rd(2'd2, d);
    check(d == {24'h0, ent(3, 5)}, "R4 entry format", d, {24'h0, ent(3, 5)});
  endtask

  task automatic t_order();
    logic [31:0] d;
    clearKeys();
    keys[2] = 8'b0001_0010; keys[0] = 8'h80; keys[9] = 8'h01;
    repeat (period(0)) @(negedge clk);
    rd(2'd2, d);
    check(d == {ent(9, 0), ent(2, 4), ent(2, 1), ent(0, 7)}, "R5 scan order", d,
          {ent(9, 0), ent(2, 4), ent(2, 1), ent(0, 7)});
    rd(2'd3, d);
    check(d == 0, "R5 unused slots zero", d, 0);
    rd(2'd1, d);
    check(d[7:4] == 4'd4, "R6 count four", 32'(d[7:4]), 4);
    keys[2] = 8'b0001_0000;
    repeat (period(0)) @(negedge clk);
    rd(2'd2, d);
    check(d == {8'h0, ent(9, 0), ent(2, 4), ent(0, 7)}, "R6 release removed", d,
          {8'h0, ent(9, 0), ent(2, 4), ent(0, 7)});
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    clearKeys();
    keys[0] = 8'h07; keys[4] = 8'h80; keys[9] = 8'h78; keys[15] = 8'h03;
    repeat (period(0)) @(negedge clk);
    rd(2'd1, d);
    check(d[7:4] == 4'd8, "R5 overflow count", 32'(d[7:4]), 8);
    rd(2'd2, d);
    check(d == {ent(4, 7), ent(0, 2), ent(0, 1), ent(0, 0)}, "R5 overflow word0", d,
          {ent(4, 7), ent(0, 2), ent(0, 1), ent(0, 0)});
    rd(2'd3, d);
    check(d == {ent(9, 6), ent(9, 5), ent(9, 4), ent(9, 3)}, "R5 overflow word1", d,
          {ent(9, 6), ent(9, 5), ent(9, 4), ent(9, 3)});
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    clearKeys();
    keys[5] = 8'h04;
    bounceEn = 1'b1;
    setCtl(1'b1, 1'b0, 4, 0);
    repeat (period(4)) @(negedge clk);
    rd(2'd2, d);
    check(d == {24'h0, ent(5, 2)}, "R3 bouncing key dropped", d, {24'h0, ent(5, 2)});
    rd(2'd1, d);
    check(d[7:4] == 4'd1, "R3 debounced count", 32'(d[7:4]), 1);
    bounceEn = 1'b0;
  endtask

  task automatic t_ctrl_readback();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, d);
    check(d == 32'h0003_FFF8, "R10 control readback", d, 32'h0003_FFF8);
    check(rowDrive == '0, "R9 disabled no rows", 32'(rowDrive), 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    clearKeys();
    keys[1] = 8'h02; keys[6] = 8'h08;
    wr(2'd1, 32'h7);
    setCtl(1'b1, 1'b0, 0, 2);
    repeat (period(0)) @(negedge clk);
    rd(2'd1, d);
    check(d[2] == 1'b1, "R7 threshold set", d, 32'h24);
    check(irq == 1'b0, "R8 irq masked", 32'(irq), 0);
    wr(2'd0, ctl(1'b1, 1'b1, 0, 2));
    check(irq == 1'b1, "R8 irq enabled", 32'(irq), 1);
    wr(2'd0, ctl(1'b0, 1'b1, 0, 2));
    check(rowDrive == '0, "R9 stop next cycle", 32'(rowDrive), 0);
    repeat (300) @(negedge clk);
    check(rowDrive == '0, "R9 stays stopped", 32'(rowDrive), 0);
    rd(2'd1, d);
    check(d[7:4] == 4'd2, "R9 count kept", 32'(d[7:4]), 2);
    wr(2'd1, 32'h7);
    rd(2'd1, d);
    check(d[2] == 1'b0, "R7 write-one clear", d, 32'h20);
    check(irq == 1'b0, "R8 irq after clear", 32'(irq), 0);
    setCtl(1'b1, 1'b1, 0, 3);
    repeat (period(0)) @(negedge clk);
    rd(2'd1, d);
    check(d[2] == 1'b0, "R7 below threshold", d, 32'h20);
    check(irq == 1'b0, "R8 irq below threshold", 32'(irq), 0);
  endtask

  initial begin
    clearKeys();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_order();
    t_overflow();
    t_debounce();
    t_ctrl_readback();
    t_threshold();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule